// File: doc/BRIEF.md
# Paged Serial Flash Erase and Program Command Decoder

This block is the slave-side command front end of a paged serial flash device. It runs on a fast system clock and oversamples the serial clock, chip select and data-in lines. While chip select is low it collects a 32-bit frame, most significant bit first. The frame is an opcode byte followed by a 24-bit address field. Three kinds of request are recognised: writing a previously erased page from one of two staging buffers, erasing a single page, and erasing an aligned group of eight pages.

Nothing starts when the last bit arrives. A frame is acted on only when chip select returns high, and only if it holds exactly 32 bits. The decoded request is then latched and presented to an abstract array port. The request is a kind, a buffer select, a start page and a page count. A busy flag then stays high for a self-timed interval that depends on the kind of request. When that interval expires, busy drops and a single-cycle completion pulse is given. Commands that complete while busy is high are dropped, and so are unknown opcodes.

Top module: `flash_cmd_front`

## Requirements
- R1: After reset, busy and done are low, arr_kind is 0 (none), arr_buf_sel is 0, arr_page is 0 and arr_count is 0.
- R2: Opcode 0x88 gives arr_kind 1 (program), arr_buf_sel 0, arr_count 1 and arr_page. arr_page is taken from the 13 address bits that follow the leading reserved bit of the address field, which are frame bits 22..10 when the last bit shifted in is bit 0.
- R3: Opcode 0x89 gives the same request as 0x88, except that arr_buf_sel is 1, which selects the second buffer.
- R4: Opcode 0x81 gives arr_kind 2 (page erase), arr_buf_sel 0, arr_count 1, and arr_page from frame bits 22..10.
- R5: Opcode 0x50 gives arr_kind 3 (block erase), arr_buf_sel 0 and arr_count 8. arr_page is the 10-bit block number from frame bits 22..13 followed by three zero bits, so the three lowest page bits of the frame have no effect.
- R6: A request is acted on only at a rising edge of chip select after exactly 32 rising serial-clock edges with chip select low. A frame with 31 or 33 bits leaves busy low.
- R7: A frame with any other opcode leaves busy low and the array outputs unchanged.
- R8: Busy stays high for exactly PROG_CYCLES, PERASE_CYCLES or BERASE_CYCLES system clock cycles, according to the accepted kind.
- R9: done is high for exactly one cycle, which is the first cycle in which busy is low after an interval. done is never high while busy is high.
- R10: A frame whose chip-select rise is acted on while busy is still high, including in the last busy cycle, is ignored. While busy is high, all array outputs hold their values.
- R11: Data is sampled on rising serial-clock edges, most significant bit first. The reserved bit (frame bit 23) and the trailing don't-care bits do not change the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock; data is sampled on its rising edges |
| spi_cs_n | input | 1 | Chip select, active low; its rising edge ends a frame |
| spi_mosi | input | 1 | Serial data in |
| busy | output | 1 | High for the whole self-timed operation |
| done | output | 1 | One-cycle pulse when an operation completes |
| arr_kind | output | 2 | 0 none, 1 program, 2 page erase, 3 block erase |
| arr_buf_sel | output | 1 | Source buffer for a program request: 0 or 1 |
| arr_page | output | 13 | First page of the requested operation |
| arr_count | output | 4 | Number of pages affected: 1 or 8 |

## Verification
Two events can fall in the same cycle: the expiry of a running interval, and the moment a new frame's chip-select rise is acted on. The bench starts a program request and records the cycle in which busy is first seen high. During the interval it shifts in a page-erase frame and holds chip select low. It then releases chip select at a sweep of offsets from two cycles before the expiry to one cycle after it. From its own cycle count, the bench predicts whether the decision cycle still lies inside the busy window. It then checks either that the first request's outputs are kept, or that the erase is taken up at once and runs its full interval.

// File: rtl/flashcmd_pkg.sv
package flashcmd_pkg;

  typedef enum logic [1:0] {
    K_NONE   = 2'd0,
    K_PROG   = 2'd1,
    K_PERASE = 2'd2,
    K_BERASE = 2'd3
  } kind_e;

  localparam logic [7:0] OPC_PROG_BUF0 = 8'h88;
  localparam logic [7:0] OPC_PROG_BUF1 = 8'h89;
  localparam logic [7:0] OPC_PAGE_ERS  = 8'h81;
  localparam logic [7:0] OPC_BLK_ERS   = 8'h50;

endpackage

// File: rtl/fc_shifter.sv
module fc_shifter #(
  parameter int FRAME_BITS = 32,
  parameter int PAGE_AW    = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sck,
  input  logic               cs_n,
  input  logic               mosi,
  output logic               frame_stb,
  output logic [7:0]         frame_op,
  output logic [PAGE_AW-1:0] frame_pa
);
  localparam int ADDR_W = FRAME_BITS - 8;
  localparam int CW     = $clog2(FRAME_BITS + 2);
  localparam logic [CW-1:0] SAT  = CW'(FRAME_BITS + 1);
  localparam logic [CW-1:0] FULL = CW'(FRAME_BITS);

  logic                  sck_q, cs_q;
  logic [FRAME_BITS-1:0] sreg;
  logic [CW-1:0]         bit_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q     <= 1'b0;
      cs_q      <= 1'b1;
      sreg      <= '0;
      bit_cnt   <= '0;
      frame_stb <= 1'b0;
      frame_op  <= '0;
      frame_pa  <= '0;
    end else begin
      sck_q     <= sck;
      cs_q      <= cs_n;
      frame_stb <= 1'b0;
      if (!cs_n && cs_q) begin
        sreg    <= '0;
        bit_cnt <= '0;
      end else if (!cs_n && sck && !sck_q) begin
        sreg <= {sreg[FRAME_BITS-2:0], mosi};
        if (bit_cnt != SAT) bit_cnt <= bit_cnt + 1'b1;
      end
      if (cs_n && !cs_q) begin
        frame_stb <= (bit_cnt == FULL);
        frame_op  <= sreg[FRAME_BITS-1 -: 8];
        frame_pa  <= sreg[ADDR_W-2 -: PAGE_AW];
      end
    end
  end

  assert_cnt_bounded_R6: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= SAT);

  assert_stb_after_release_R6: assert property (@(posedge clk) disable iff (rst)
    frame_stb |-> cs_q);

endmodule

// File: rtl/fc_decode.sv
module fc_decode
  import flashcmd_pkg::*;
#(
  parameter int PAGE_AW       = 13,
  parameter int BLK_LOG2      = 3,
  parameter int CNT_OUT_W     = 4,
  parameter int CNT_W         = 8,
  parameter int PROG_CYCLES   = 40,
  parameter int PERASE_CYCLES = 60,
  parameter int BERASE_CYCLES = 90
) (
  input  logic [7:0]           op,
  input  logic [PAGE_AW-1:0]   pa,
  output kind_e                kind,
  output logic                 buf_sel,
  output logic [PAGE_AW-1:0]   page,
  output logic [CNT_OUT_W-1:0] count,
  output logic [CNT_W-1:0]     dur_m1
);
  localparam logic [CNT_OUT_W-1:0] ONE_PAGE  = CNT_OUT_W'(1);
  localparam logic [CNT_OUT_W-1:0] BLK_PAGES = CNT_OUT_W'(1 << BLK_LOG2);

  always_comb begin
    kind    = K_NONE;
    buf_sel = 1'b0;
    page    = pa;
    count   = ONE_PAGE;
    dur_m1  = CNT_W'(PROG_CYCLES - 1);
    case (op)
      OPC_PROG_BUF0: kind = K_PROG;
      OPC_PROG_BUF1: begin
        kind    = K_PROG;
        buf_sel = 1'b1;
      end
      OPC_PAGE_ERS: begin
        kind   = K_PERASE;
        dur_m1 = CNT_W'(PERASE_CYCLES - 1);
      end
      OPC_BLK_ERS: begin
        kind   = K_BERASE;
        page   = {pa[PAGE_AW-1:BLK_LOG2], {BLK_LOG2{1'b0}}};
        count  = BLK_PAGES;
        dur_m1 = CNT_W'(BERASE_CYCLES - 1);
      end
      default: kind = K_NONE;
    endcase
  end

endmodule

// File: rtl/fc_timer.sv
module fc_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        cnt  <= load_val;
      end else if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  assert_start_only_idle_R10: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);

endmodule

// File: rtl/flash_cmd_front.sv
module flash_cmd_front
  import flashcmd_pkg::*;
#(
  parameter int PAGE_AW       = 13,
  parameter int BLK_LOG2      = 3,
  parameter int PROG_CYCLES   = 40,
  parameter int PERASE_CYCLES = 60,
  parameter int BERASE_CYCLES = 90
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  spi_sck,
  input  logic                  spi_cs_n,
  input  logic                  spi_mosi,
  output logic                  busy,
  output logic                  done,
  output logic [1:0]            arr_kind,
  output logic                  arr_buf_sel,
  output logic [PAGE_AW-1:0]    arr_page,
  output logic [BLK_LOG2:0]     arr_count
);
  localparam int FRAME_BITS = 32;
  localparam int CNT_OUT_W  = BLK_LOG2 + 1;
  localparam int MAX_A      = (PROG_CYCLES > PERASE_CYCLES) ? PROG_CYCLES : PERASE_CYCLES;
  localparam int MAX_D      = (MAX_A > BERASE_CYCLES) ? MAX_A : BERASE_CYCLES;
  localparam int CNT_W      = $clog2(MAX_D + 1);

  logic                 frame_stb;
  logic [7:0]           frame_op;
  logic [PAGE_AW-1:0]   frame_pa;
  kind_e                dec_kind;
  logic                 dec_buf;
  logic [PAGE_AW-1:0]   dec_page;
  logic [CNT_OUT_W-1:0] dec_count;
  logic [CNT_W-1:0]     dec_dur;
  logic                 accept;

  fc_shifter #(.FRAME_BITS(FRAME_BITS), .PAGE_AW(PAGE_AW)) u_shift (
    .clk(clk), .rst(rst), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .frame_stb(frame_stb), .frame_op(frame_op), .frame_pa(frame_pa)
  );

  fc_decode #(
    .PAGE_AW(PAGE_AW), .BLK_LOG2(BLK_LOG2), .CNT_OUT_W(CNT_OUT_W), .CNT_W(CNT_W),
    .PROG_CYCLES(PROG_CYCLES), .PERASE_CYCLES(PERASE_CYCLES),
    .BERASE_CYCLES(BERASE_CYCLES)
  ) u_dec (
    .op(frame_op), .pa(frame_pa), .kind(dec_kind), .buf_sel(dec_buf),
    .page(dec_page), .count(dec_count), .dur_m1(dec_dur)
  );

  assign accept = frame_stb && (dec_kind != K_NONE) && !busy;

  fc_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst(rst), .start(accept), .load_val(dec_dur),
    .busy(busy), .done(done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      arr_kind    <= K_NONE;
      arr_buf_sel <= 1'b0;
      arr_page    <= '0;
      arr_count   <= '0;
    end else if (accept) begin
      arr_kind    <= dec_kind;
      arr_buf_sel <= dec_buf;
      arr_page    <= dec_page;
      arr_count   <= dec_count;
    end
  end

  assert_hold_while_busy_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(arr_kind) && $stable(arr_page) &&
                               $stable(arr_buf_sel) && $stable(arr_count)));

  assert_count_legal_R5: assert property (@(posedge clk) disable iff (rst)
    busy |-> (arr_count == CNT_OUT_W'(1) || arr_count == CNT_OUT_W'(1 << BLK_LOG2)));

  assert_block_aligned_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && arr_kind == K_BERASE) |-> (arr_page[BLK_LOG2-1:0] == '0));

  assert_known_kind_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (arr_kind != K_NONE));

endmodule

// File: tb/sim_flash_cmd_front.sv
module sim_flash_cmd_front;
  localparam int CLK_P  = 10;
  localparam int PROG   = 200;
  localparam int PERASE = 230;
  localparam int BERASE = 260;

  logic        clk = 1'b0, rst = 1'b1;
  logic        sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic        busy, done, buf_sel;
  logic [1:0]  kind;
  logic [12:0] page;
  logic [3:0]  count;
  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  flash_cmd_front #(.PROG_CYCLES(PROG), .PERASE_CYCLES(PERASE), .BERASE_CYCLES(BERASE)) u0 (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .busy(busy), .done(done), .arr_kind(kind), .arr_buf_sel(buf_sel),
    .arr_page(page), .arr_count(count)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected model from the requirements
  function automatic int e_kind(input logic [7:0] op);
    case (op) 8'h88, 8'h89: return 1; 8'h81: return 2; 8'h50: return 3; default: return 0; endcase
  endfunction
  function automatic int e_page(input logic [7:0] op, input logic [23:0] a);
    if (op == 8'h50) return int'({a[22:13], 3'b000});
    return int'(a[22:10]);
  endfunction
  function automatic int e_dur(input int k);
    return (k == 1) ? PROG : (k == 2) ? PERASE : BERASE;
  endfunction

  task automatic shift_frame(input logic [39:0] w, input int n);
    @(negedge clk); sck = 0; cs_n = 0;
    repeat (2) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = w[i]; sck = 0;
      repeat (2) @(negedge clk);
      sck = 1;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic release_cs();
    cs_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic expect_run(input int k, input int bs, input int pg, input int cn, input string req);
    int n = 1;
    chk(busy == 1, {req, " busy"}, busy, 1);
    chk(kind == k[1:0], {req, " kind"}, kind, k);
    chk(buf_sel == bs[0], {req, " buf"}, buf_sel, bs);
    chk(page == pg[12:0], {req, " page"}, page, pg);
    chk(count == cn[3:0], {req, " count"}, count, cn);
    forever begin
      @(negedge clk);
      if (!busy) break;
      n++;
      if (done || kind != k[1:0] || page != pg[12:0])
        chk(0, "R10 hold/R9 done", {kind, page}, {k[1:0], pg[12:0]});
    end
    chk(n == e_dur(k), "R8 busy length", n, e_dur(k));
    chk(done == 1, "R9 done pulse", done, 1);
    @(negedge clk);
    chk(done == 0, "R9 done width", done, 0);
  endtask

  task automatic expect_idle(input string req);
    bit bad = 0;
    for (int i = 0; i < 4; i++) begin
      if (busy || done) bad = 1;
      @(negedge clk);
    end
    chk(!bad, req, busy, 0);
  endtask

  task automatic run(input logic [7:0] op, input logic [23:0] a, input int n, input string req);
    int k;
    shift_frame({8'h00, op, a} | ((n > 32) ? 40'h01_0000_0000 : 40'h0), n);
    release_cs();
    k = (n == 32) ? e_kind(op) : 0;
    if (k != 0) expect_run(k, (op == 8'h89) ? 1 : 0, e_page(op, a), (k == 3) ? 8 : 1, req);
    else expect_idle(req);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(busy == 0 && done == 0, "R1 reset busy/done", busy, 0);
    chk(kind == 0 && buf_sel == 0, "R1 reset kind/buf", kind, 0);
    chk(page == 0 && count == 0, "R1 reset page/count", page, 0);

    run(8'h88, 24'h2AAC00, 32, "R2 program buf0");
    run(8'h89, 24'h7FFC00, 32, "R3 program buf1");
    run(8'h81, 24'h000400, 32, "R4 page erase");
    run(8'h50, 24'h7FFFFF, 32, "R5 block erase top");
    run(8'h50, 24'h00FC00, 32, "R5 block erase low bits ignored");
    run(8'h88, 24'h1ABC00, 31, "R6 short frame");
    run(8'h88, 24'h1ABC00, 33, "R6 long frame");
    run(8'h42, 24'h123456, 32, "R7 unknown opcode");
    run(8'h88, 24'hC003FF, 32, "R11 reserved and trailing bits set");
    run(8'h88, 24'h400000, 32, "R11 msb of page");

    // same-cycle sweep: frame decision near the end of a program interval
    for (int off = 0; off < 4; off++) begin
      int c0, m;
      m = PROG - 2 + off;
      shift_frame({16'h0088, 24'h0C0000}, 32);
      release_cs();
      c0 = cyc;
      chk(busy == 1, "R10 first request", busy, 1);
      shift_frame({16'h0081, 24'h154000}, 32);
      while (cyc < c0 + m - 1) @(negedge clk);
      release_cs();
      if (m >= PROG) begin
        expect_run(2, 0, int'(13'h0550), 1, "R10 taken after expiry");
      end else begin
        chk(kind == 2'd1 && page == 13'h0300, "R10 ignored while busy", page, 13'h0300);
        chk(busy == (m + 2 <= PROG), "R8 R10 busy at edge", busy, (m + 2 <= PROG));
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(kind == 2'd1, "R10 late frame dropped", kind, 1);
      end
    end

    for (int i = 0; i < 40; i++) begin
      logic [7:0] op;
      int sel = $urandom_range(0, 5), nb = 32;
      op = (sel == 0) ? 8'h88 : (sel == 1) ? 8'h89 : (sel == 2) ? 8'h81 :
           (sel == 3) ? 8'h50 : 8'($urandom());
      if ($urandom_range(0, 9) == 0) nb = ($urandom_range(0, 1) == 0) ? 31 : 33;
      run(op, 24'($urandom()), nb, "R2 R3 R4 R5 R6 R7 random");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule